// File: doc/BRIEF.md
# Keyboard Controller Host Interface

This block is the host-facing register front end of a two-channel serial-input controller: one channel serves a keyboard, the other an auxiliary pointing device. The host sees two byte-wide ports picked by a single select bit. Reading the command side returns a status byte. Writing it issues a controller command. The data side carries received bytes to the host and host bytes out to the devices.

Some commands are two-phase: they latch themselves, and the next data-side write is steered to the mode register, the output-port register, one of the two receive slots, or the auxiliary transmit path. Other commands answer with a generated byte, which is placed in the keyboard receive slot as if the keyboard had sent it.

Each channel has a one-byte receive slot, filled from a valid/ready stream on the device side. The keyboard slot always wins the host read. Two interrupt lines flag the waiting byte, each gated by its own mode bits. Line serialisation, device behaviour and scan-code translation live in neighbouring blocks.

Top module: `kbc_host_if`

## Requirements
- R1: After reset, status reads 0x18, the mode register reads 0x03 (via command 0x20), `out_port` is 0xCF, both interrupts are low and neither transmit stream is valid.
- R2: A command-side read returns status with this layout: bit0 set when any receive slot is full; bit5 set when only the aux slot is full; bit2 self-test passed; bit3 set by a command-side write and cleared by a data-side write; bit4 always 1; bits 1, 6 and 7 always 0.
- R3: Command 0x20 queues the mode byte. 0xAA sets status bit2 and queues 0x55. 0xA9 and 0xAB queue 0x00. 0xC0 queues 0x80. Each queued byte goes to the keyboard slot.
- R4: After command 0x60, 0xD1, 0xD2, 0xD3 or 0xD4, the next data-side write goes, in that order, to the mode register, `out_port`, the keyboard slot, the aux slot, or the aux transmit stream. The latched command is then cleared.
- R5: A data-side write with no latched command is sent on the keyboard transmit stream.
- R6: 0xA7 sets mode bit5 and 0xA8 clears it. 0xAD sets mode bit4 and 0xAE clears it. The interrupt lines follow the new mode at once.
- R7: A data-side read returns the keyboard slot's byte when it is full. It returns the aux byte only when the keyboard slot is empty.
- R8: `irq_kbd` is high when the keyboard slot is full, mode bit0 is 1 and mode bit4 is 0. `irq_aux` is high when only the aux slot is full and mode bit1 is 1. The two are never high together.
- R9: A command code not listed in R3, R4 or R6 changes neither the mode register, nor the latched command, nor any slot. Only status bit3 is updated.
- R10: A data-side read removes the returned byte at that clock edge. The next read or status read reflects the remaining slot.
- R11: A generated response takes precedence over a keyboard byte arriving in the same cycle. The device's ready stays low, and its byte is accepted only after the response has been read.
- R12: A receive stream is ready only while its slot is empty. A transmit stream holds valid and data stable until ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | 0 = data side, 1 = command/status side |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (data-side read pops a byte) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational) |
| kbd_rx_valid | input | 1 | Keyboard byte offered |
| kbd_rx_data | input | 8 | Keyboard byte |
| kbd_rx_ready | output | 1 | Keyboard slot can take the byte |
| aux_rx_valid | input | 1 | Aux byte offered |
| aux_rx_data | input | 8 | Aux byte |
| aux_rx_ready | output | 1 | Aux slot can take the byte |
| kbd_tx_valid | output | 1 | Byte for the keyboard is waiting |
| kbd_tx_data | output | 8 | Byte for the keyboard |
| kbd_tx_ready | input | 1 | Keyboard side takes the byte |
| aux_tx_valid | output | 1 | Byte for the aux device is waiting |
| aux_tx_data | output | 8 | Byte for the aux device |
| aux_tx_ready | input | 1 | Aux side takes the byte |
| out_port | output | 8 | Output-port register |
| irq_kbd | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Aux interrupt level |

## Verification
Two functions can land on the keyboard slot in the same cycle: a response-generating command and a byte arriving from the keyboard stream. The bench raises the stream's valid on the same edge as a 0xAA command write. It checks that ready is low in that cycle, that the first read returns 0x55, and that the held byte 0x77 is accepted and read afterwards. The randomised loop also fills both slots at once and judges read order, status and interrupt levels against bench functions.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

  // status bit positions
  localparam int ST_OBF  = 0;
  localparam int ST_PASS = 2;
  localparam int ST_CMD  = 3;
  localparam int ST_UNLK = 4;
  localparam int ST_AOBF = 5;

  // mode bit positions
  localparam int MD_KIRQ = 0;
  localparam int MD_AIRQ = 1;
  localparam int MD_KDIS = 4;
  localparam int MD_ADIS = 5;

  localparam logic [7:0] MODE_RST = 8'h03;
  localparam logic [7:0] OUTP_RST = 8'hCF;

  typedef enum logic [2:0] {
    PW_NONE, PW_MODE, PW_OUTP, PW_KBDQ, PW_AUXQ, PW_AUXTX
  } pend_t;

  typedef struct packed {
    logic       known;
    logic       resp;
    logic       use_mode;
    logic [7:0] resp_byte;
    logic       latch;
    pend_t      pend;
    logic       pass;
    logic [7:0] mset;
    logic [7:0] mclr;
  } cmd_act_t;

  function automatic cmd_act_t decode_cmd(input logic [7:0] c);
    cmd_act_t a;
    a.known     = 1'b1;
    a.resp      = 1'b0;
    a.use_mode  = 1'b0;
    a.resp_byte = 8'h00;
    a.latch     = 1'b0;
    a.pend      = PW_NONE;
    a.pass      = 1'b0;
    a.mset      = 8'h00;
    a.mclr      = 8'h00;
    case (c)
      8'h20: begin a.resp = 1'b1; a.use_mode = 1'b1; end
      8'h60: begin a.latch = 1'b1; a.pend = PW_MODE;  end
      8'hD1: begin a.latch = 1'b1; a.pend = PW_OUTP;  end
      8'hD2: begin a.latch = 1'b1; a.pend = PW_KBDQ;  end
      8'hD3: begin a.latch = 1'b1; a.pend = PW_AUXQ;  end
      8'hD4: begin a.latch = 1'b1; a.pend = PW_AUXTX; end
      8'hA7: a.mset[MD_ADIS] = 1'b1;
      8'hA8: a.mclr[MD_ADIS] = 1'b1;
      8'hAD: a.mset[MD_KDIS] = 1'b1;
      8'hAE: a.mclr[MD_KDIS] = 1'b1;
      8'hA9, 8'hAB: a.resp = 1'b1;
      8'hAA: begin a.resp = 1'b1; a.resp_byte = 8'h55; a.pass = 1'b1; end
      8'hC0: begin a.resp = 1'b1; a.resp_byte = 8'h80; end
      default: a.known = 1'b0;
    endcase
    return a;
  endfunction

  function automatic logic [7:0] pack_status(input logic kf, input logic af,
                                             input logic pass, input logic cmdf);
    logic [7:0] s;
    s          = 8'h00;
    s[ST_OBF]  = kf | af;
    s[ST_PASS] = pass;
    s[ST_CMD]  = cmdf;
    s[ST_UNLK] = 1'b1;
    s[ST_AOBF] = af & ~kf;
    return s;
  endfunction

  function automatic logic kbd_irq_lvl(input logic kf, input logic [7:0] m);
    return kf & m[MD_KIRQ] & ~m[MD_KDIS];
  endfunction

  function automatic logic aux_irq_lvl(input logic kf, input logic af,
                                       input logic [7:0] m);
    return af & ~kf & m[MD_AIRQ];
  endfunction

endpackage

// File: rtl/kbc_cmd_dec.sv
module kbc_cmd_dec
  import kbc_pkg::*;
(
  input  logic [7:0] cmd,
  output cmd_act_t   act
);
  assign act = decode_cmd(cmd);
endmodule

// File: rtl/kbc_rx_slot.sv
module kbc_rx_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dev_valid,
  input  logic [W-1:0] dev_data,
  output logic         dev_ready,
  input  logic         inj,
  input  logic [W-1:0] inj_data,
  input  logic         pop,
  output logic         full,
  output logic [W-1:0] data
);
  logic dev_take;

  assign dev_ready = ~full & ~inj;
  assign dev_take  = dev_valid & dev_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (inj) begin
      full <= 1'b1;
      data <= inj_data;
    end else if (pop) begin
      full <= 1'b0;
    end else if (dev_take) begin
      full <= 1'b1;
      data <= dev_data;
    end
  end

  AST_DEV_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_take |=> full && data == $past(dev_data)); // R12
  AST_INJ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (inj && dev_valid) |=> full && data == $past(inj_data)); // R11
  AST_POP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !inj) |=> !full); // R10
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !inj) |=> full && $stable(data)); // R12
endmodule

// File: rtl/kbc_tx_hold.sv
module kbc_tx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         valid,
  output logic [W-1:0] data,
  input  logic         ready
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  AST_TX_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> valid && $stable(data)); // R12
  AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid && data == $past(load_data)); // R5
endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
  import kbc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          kbd_rx_valid,
  input  logic [DW-1:0] kbd_rx_data,
  output logic          kbd_rx_ready,
  input  logic          aux_rx_valid,
  input  logic [DW-1:0] aux_rx_data,
  output logic          aux_rx_ready,
  output logic          kbd_tx_valid,
  output logic [DW-1:0] kbd_tx_data,
  input  logic          kbd_tx_ready,
  output logic          aux_tx_valid,
  output logic [DW-1:0] aux_tx_data,
  input  logic          aux_tx_ready,
  output logic [DW-1:0] out_port,
  output logic          irq_kbd,
  output logic          irq_aux
);
  // named events
  logic ev_cmd_wr, ev_dat_wr, ev_dat_rd, ev_pop_kbd, ev_pop_aux;
  logic ev_kbd_inj, ev_aux_inj, ev_ktx_load, ev_atx_load;

  cmd_act_t          act;
  pend_t             pend_q;
  logic [DW-1:0]     mode_q;
  logic              pass_q, cmdf_q;
  logic              kbd_full, aux_full;
  logic [DW-1:0]     kbd_byte, aux_byte, kbd_inj_data;
  logic [DW-1:0]     status;

  assign ev_cmd_wr = host_wr &  host_sel;
  assign ev_dat_wr = host_wr & ~host_sel;
  assign ev_dat_rd = host_rd & ~host_sel;

  kbc_cmd_dec u_dec (.cmd(host_wdata), .act(act));

  assign ev_pop_kbd  = ev_dat_rd & kbd_full;
  assign ev_pop_aux  = ev_dat_rd & ~kbd_full & aux_full;
  assign ev_kbd_inj  = (ev_cmd_wr & act.resp) | (ev_dat_wr & (pend_q == PW_KBDQ));
  assign ev_aux_inj  = ev_dat_wr & (pend_q == PW_AUXQ);
  assign ev_ktx_load = ev_dat_wr & (pend_q == PW_NONE);
  assign ev_atx_load = ev_dat_wr & (pend_q == PW_AUXTX);

  always_comb begin
    if (ev_cmd_wr) kbd_inj_data = act.use_mode ? mode_q : act.resp_byte;
    else           kbd_inj_data = host_wdata;
  end

  // register state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= PW_NONE;
      mode_q   <= MODE_RST;
      pass_q   <= 1'b0;
      cmdf_q   <= 1'b1;
      out_port <= OUTP_RST;
    end else if (ev_cmd_wr) begin
      cmdf_q <= 1'b1;
      if (act.latch) pend_q <= act.pend;
      if (act.pass)  pass_q <= 1'b1;
      mode_q <= (mode_q | act.mset) & ~act.mclr;
    end else if (ev_dat_wr) begin
      cmdf_q <= 1'b0;
      pend_q <= PW_NONE;
      if (pend_q == PW_MODE) mode_q   <= host_wdata;
      if (pend_q == PW_OUTP) out_port <= host_wdata;
    end
  end

  kbc_rx_slot #(.W(DW)) u_kslot (
    .clk(clk), .rst_n(rst_n),
    .dev_valid(kbd_rx_valid), .dev_data(kbd_rx_data), .dev_ready(kbd_rx_ready),
    .inj(ev_kbd_inj), .inj_data(kbd_inj_data), .pop(ev_pop_kbd),
    .full(kbd_full), .data(kbd_byte));

  kbc_rx_slot #(.W(DW)) u_aslot (
    .clk(clk), .rst_n(rst_n),
    .dev_valid(aux_rx_valid), .dev_data(aux_rx_data), .dev_ready(aux_rx_ready),
    .inj(ev_aux_inj), .inj_data(host_wdata), .pop(ev_pop_aux),
    .full(aux_full), .data(aux_byte));

  kbc_tx_hold #(.W(DW)) u_ktx (
    .clk(clk), .rst_n(rst_n), .load(ev_ktx_load), .load_data(host_wdata),
    .valid(kbd_tx_valid), .data(kbd_tx_data), .ready(kbd_tx_ready));

  kbc_tx_hold #(.W(DW)) u_atx (
    .clk(clk), .rst_n(rst_n), .load(ev_atx_load), .load_data(host_wdata),
    .valid(aux_tx_valid), .data(aux_tx_data), .ready(aux_tx_ready));

  assign status     = pack_status(kbd_full, aux_full, pass_q, cmdf_q);
  assign host_rdata = host_sel ? status : (kbd_full ? kbd_byte : aux_byte);
  assign irq_kbd    = kbd_irq_lvl(kbd_full, mode_q);
  assign irq_aux    = aux_irq_lvl(kbd_full, aux_full, mode_q);

  AST_PEND_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dat_wr |=> pend_q == PW_NONE); // R4
  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_kbd && irq_aux)); // R8
  AST_KBD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dat_rd && kbd_full && aux_full) |=> aux_full); // R7
  AST_UNKNOWN_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd_wr && !act.known) |=> $stable(mode_q) && $stable(pend_q)); // R9
  AST_PASS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q |=> pass_q); // R3
  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dat_wr && pend_q == PW_MODE) |=> mode_q == $past(host_wdata)); // R4
endmodule

// File: tb/kbc_host_if_tb.sv
module kbc_host_if_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00, host_rdata;
  logic kbd_rx_valid = 1'b0, aux_rx_valid = 1'b0;
  logic [7:0] kbd_rx_data = 8'h00, aux_rx_data = 8'h00;
  logic kbd_rx_ready, aux_rx_ready;
  logic kbd_tx_valid, aux_tx_valid;
  logic [7:0] kbd_tx_data, aux_tx_data, out_port;
  logic kbd_tx_ready = 1'b0, aux_tx_ready = 1'b0;
  logic irq_kbd, irq_aux;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit pass_seen = 0;

  always #10 clk = ~clk;

  kbc_host_if u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .kbd_rx_valid(kbd_rx_valid), .kbd_rx_data(kbd_rx_data), .kbd_rx_ready(kbd_rx_ready),
    .aux_rx_valid(aux_rx_valid), .aux_rx_data(aux_rx_data), .aux_rx_ready(aux_rx_ready),
    .kbd_tx_valid(kbd_tx_valid), .kbd_tx_data(kbd_tx_data), .kbd_tx_ready(kbd_tx_ready),
    .aux_tx_valid(aux_tx_valid), .aux_tx_data(aux_tx_data), .aux_tx_ready(aux_tx_ready),
    .out_port(out_port), .irq_kbd(irq_kbd), .irq_aux(irq_aux));

  // expected-value functions
  function automatic logic [7:0] e_status(bit k, bit a, bit ps, bit cf);
    return {2'b00, (a && !k), 1'b1, cf, ps, 1'b0, (k || a)};
  endfunction
  function automatic bit e_irq1(bit k, logic [7:0] m);
    return k && m[0] && !m[4];
  endfunction
  function automatic bit e_irq12(bit k, bit a, logic [7:0] m);
    return a && !k && m[1];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input bit sel, output logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic get_mode(output logic [7:0] m);
    wr(1'b1, 8'h20);
    rd(1'b0, m);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v, m;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R1 reset state
    chk(host_sel == 0 && u_dut.host_rdata !== 8'hxx, "R1 rdata known", host_rdata, host_rdata);
    rd(1'b1, v);  chk(v == 8'h18, "R1 status", v, 8'h18);
    chk(out_port == 8'hCF, "R1 out_port", out_port, 8'hCF);
    chk(!irq_kbd && !irq_aux, "R1 irqs", {irq_kbd, irq_aux}, 8'h00);
    chk(!kbd_tx_valid && !aux_tx_valid, "R1 tx idle", {kbd_tx_valid, aux_tx_valid}, 8'h00);
    get_mode(m);  chk(m == 8'h03, "R1 mode", m, 8'h03);

    // R3 response commands
    wr(1'b1, 8'hAA);
    rd(1'b1, v);  chk(v == e_status(1, 0, 1, 1), "R3 selftest status", v, e_status(1, 0, 1, 1));
    rd(1'b0, v);  chk(v == 8'h55, "R3 selftest byte", v, 8'h55);
    pass_seen = 1;
    wr(1'b1, 8'hA9); rd(1'b0, v); chk(v == 8'h00, "R3 0xA9", v, 8'h00);
    wr(1'b1, 8'hAB); rd(1'b0, v); chk(v == 8'h00, "R3 0xAB", v, 8'h00);
    wr(1'b1, 8'hC0); rd(1'b0, v); chk(v == 8'h80, "R3 0xC0", v, 8'h80);
    rd(1'b1, v);  chk(v == e_status(0, 0, 1, 1), "R10 empty after pops", v, e_status(0, 0, 1, 1));

    // R4 output port and status bit3
    wr(1'b1, 8'hD1); wr(1'b0, 8'hA5);
    chk(out_port == 8'hA5, "R4 out_port", out_port, 8'hA5);
    chk(!kbd_tx_valid, "R4 not forwarded", {7'd0, kbd_tx_valid}, 8'h00);
    rd(1'b1, v);  chk(v == e_status(0, 0, 1, 0), "R2 cmd flag cleared", v, e_status(0, 0, 1, 0));

    // R4/R12 aux transmit
    wr(1'b1, 8'hD4); wr(1'b0, 8'h3C);
    chk(aux_tx_valid && aux_tx_data == 8'h3C, "R4 aux tx", aux_tx_data, 8'h3C);
    @(negedge clk);
    chk(aux_tx_valid && aux_tx_data == 8'h3C, "R12 aux tx held", aux_tx_data, 8'h3C);
    aux_tx_ready = 1'b1; @(negedge clk); aux_tx_ready = 1'b0;
    chk(!aux_tx_valid, "R12 aux tx released", {7'd0, aux_tx_valid}, 8'h00);

    // R5 plain data write
    wr(1'b0, 8'hED);
    chk(kbd_tx_valid && kbd_tx_data == 8'hED, "R5 kbd tx", kbd_tx_data, 8'hED);
    chk(!aux_tx_valid, "R5 aux idle", {7'd0, aux_tx_valid}, 8'h00);
    kbd_tx_ready = 1'b1; @(negedge clk); kbd_tx_ready = 1'b0;
    chk(!kbd_tx_valid, "R12 kbd tx released", {7'd0, kbd_tx_valid}, 8'h00);

    // R6 mode bit commands
    wr(1'b1, 8'hA7); get_mode(m); chk(m == 8'h23, "R6 0xA7", m, 8'h23);
    wr(1'b1, 8'hA8); get_mode(m); chk(m == 8'h03, "R6 0xA8", m, 8'h03);
    wr(1'b1, 8'hAD);
    wr(1'b1, 8'hD2); wr(1'b0, 8'h11);
    chk(!irq_kbd, "R6 irq_kbd masked by bit4", {7'd0, irq_kbd}, 8'h00);
    wr(1'b1, 8'hAE);
    chk(irq_kbd, "R6 irq_kbd after 0xAE", {7'd0, irq_kbd}, 8'h01);
    rd(1'b0, v);  chk(v == 8'h11, "R4 kbd queue byte", v, 8'h11);

    // R9 unknown command
    wr(1'b1, 8'h5A); get_mode(m); chk(m == 8'h03, "R9 mode kept", m, 8'h03);
    rd(1'b1, v);  chk(v == e_status(0, 0, 1, 1), "R9 no slot change", v, e_status(0, 0, 1, 1));
    wr(1'b1, 8'h60); wr(1'b1, 8'h5A); wr(1'b0, 8'h47);
    get_mode(m);  chk(m == 8'h47, "R9 latch kept", m, 8'h47);
    chk(!kbd_tx_valid, "R9 no forward", {7'd0, kbd_tx_valid}, 8'h00);
    wr(1'b1, 8'h60); wr(1'b0, 8'h03);

    // R11 response vs device byte in the same cycle
    @(negedge clk);
    kbd_rx_valid = 1'b1; kbd_rx_data = 8'h77;
    host_sel = 1'b1; host_wr = 1'b1; host_wdata = 8'hAA;
    #1 chk(!kbd_rx_ready, "R11 ready low on inject", {7'd0, kbd_rx_ready}, 8'h00);
    @(negedge clk); host_wr = 1'b0;
    #1 chk(!kbd_rx_ready, "R12 ready low when full", {7'd0, kbd_rx_ready}, 8'h00);
    rd(1'b0, v);  chk(v == 8'h55, "R11 response first", v, 8'h55);
    #1 chk(kbd_rx_ready, "R11 ready after pop", {7'd0, kbd_rx_ready}, 8'h01);
    @(negedge clk); kbd_rx_valid = 1'b0;
    rd(1'b0, v);  chk(v == 8'h77, "R11 device byte kept", v, 8'h77);

    // R7/R10 both slots, then aux stream
    wr(1'b1, 8'hD3); wr(1'b0, 8'h99);
    wr(1'b1, 8'hD2); wr(1'b0, 8'h22);
    rd(1'b0, v);  chk(v == 8'h22, "R7 kbd first", v, 8'h22);
    rd(1'b1, v);  chk(v == e_status(0, 1, 1, 0), "R10 aux remains", v, e_status(0, 1, 1, 0));
    chk(irq_aux && !irq_kbd, "R8 aux irq", {irq_kbd, irq_aux}, 8'h01);
    rd(1'b0, v);  chk(v == 8'h99, "R7 aux next", v, 8'h99);
    @(negedge clk); aux_rx_valid = 1'b1; aux_rx_data = 8'h5B;
    #1 chk(aux_rx_ready, "R12 aux ready when empty", {7'd0, aux_rx_ready}, 8'h01);
    @(negedge clk); aux_rx_valid = 1'b0;
    chk(irq_aux, "R12 aux byte accepted", {7'd0, irq_aux}, 8'h01);
    rd(1'b0, v);  chk(v == 8'h5B, "R12 aux stream byte", v, 8'h5B);

    // randomised: R2 R7 R8 R10
    for (int i = 0; i < 200; i++) begin
      logic [7:0] rm, kb, ab;
      bit k, a;
      rm = 8'($urandom);
      kb = 8'($urandom);
      ab = 8'($urandom);
      k = 1'($urandom);
      a = 1'($urandom);
      wr(1'b1, 8'h60); wr(1'b0, rm);
      if (a) begin wr(1'b1, 8'hD3); wr(1'b0, ab); end
      if (k) begin wr(1'b1, 8'hD2); wr(1'b0, kb); end
      rd(1'b1, v);
      chk(v == e_status(k, a, pass_seen, 0), "R2 random status", v, e_status(k, a, pass_seen, 0));
      chk(irq_kbd == e_irq1(k, rm), "R8 random irq_kbd", {7'd0, irq_kbd}, {7'd0, e_irq1(k, rm)});
      chk(irq_aux == e_irq12(k, a, rm), "R8 random irq_aux", {7'd0, irq_aux}, {7'd0, e_irq12(k, a, rm)});
      if (k) begin rd(1'b0, v); chk(v == kb, "R7 random kbd byte", v, kb); end
      if (a) begin rd(1'b0, v); chk(v == ab, "R7 random aux byte", v, ab); end
      rd(1'b1, v);
      chk(v == e_status(0, 0, pass_seen, 0), "R10 random drained", v, e_status(0, 0, pass_seen, 0));
    end
    wr(1'b1, 8'h60); wr(1'b0, 8'h03);
    finish_run();
  end
endmodule